// File: doc/BRIEF.md
# Clock-Sampled Parallel Read Port

This block sits between a converter core and a host data bus. The core hands over a finished output word with a one-cycle update strobe, once per word period (64 master-clock cycles by default). The block holds that word in an output register and tells the host through an active-low ready flag that a word is waiting. The host reads it by pulling chip-select and read low.

Chip-select and read are level inputs. They are sampled only on the rising edge of the master clock and are never used as asynchronous strobes. The bus driver enable is a registered output. The pad drives the data lines while it is high and leaves them floating while it is low. The word shown on the bus is captured when a read begins and stays fixed until that read ends, even if the core delivers a newer word in the meantime.

The ready flag goes high once a read finishes. If the host skips a word entirely, the flag rises for a short window just before the next update and falls again on that update. This gives the host an edge to wait on for every word.

Top module: `pbus_read_if`

## Requirements
- R1: While reset is high and in the cycle after it, `rdy_n` is 1, `bus_oe` is 0 and `bus_dq` is 0.
- R2: `bus_oe` is 1 in the cycle after a rising edge that samples both `cs_n` and `rd_n` low. It is 0 after any edge that samples either of them high.
- R3: At the first edge of a read (qualified now, not qualified at the previous edge), `bus_dq` takes the word held in the output register. `bus_dq` does not change again until the next read begins, even if an update arrives during the read.
- R4: An edge that samples `upd_stb` high loads `upd_word` into the output register and drives `rdy_n` to 0 from the next cycle.
- R5: A read ends at the first edge where the qualified condition is gone. If no update arrived since that read began, `rdy_n` is 1 from the next cycle.
- R6: If the word that is waiting has not been read, `rdy_n` is 1 for the last `PRE_PULSE` cycles of the word period (the edge at phase `WORD_PERIOD-PRE_PULSE-1` after the update raises it). It returns to 0 on the next update. The phase counts 0 in the cycle after an update.
- R7: If an update arrived during a read, or at the edge where the read began, the end of that read leaves `rdy_n` low, because the newer word is still unread.
- R8: When an update and the end of a read fall on the same edge, the update wins: `rdy_n` is 0 and the new word counts as unread.
- R9: A second read of a word that was already read leaves `rdy_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle strobe from the core: a new word is present |
| upd_word | input | DATA_W | Word delivered with the strobe |
| cs_n | input | 1 | Chip-select, active low, level sensitive |
| rd_n | input | 1 | Read, active low, level sensitive |
| rdy_n | output | 1 | Ready flag, active low; a falling edge marks a new word |
| bus_oe | output | 1 | Data-pad drive enable; bus floats while 0 |
| bus_dq | output | DATA_W | Data presented to the bus pads |

## Verification
The bench builds the block with an 8-cycle word period and a 2-cycle warning window, and keeps the 16-bit word width. With the period this short, it can sweep every read start phase within a period against read lengths from 1 to 10 cycles. That sweep covers reads that straddle an update, reads that end exactly on an update edge, and reads that overlap the warning window. Each sweep point runs three ways: with both selects asserted, with chip-select held off, and with chip-select gating a longer read pulse. A reference model in the bench, built from the requirements, predicts the flag, the enable and the bus word every cycle.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  // Read transitions derived from the sampled select lines
  typedef struct packed {
    logic start;   // qualified now, not at the previous edge
    logic stop;    // qualified at the previous edge, not now
  } rd_evt_t;

endpackage

// File: rtl/pbus_phase.sv
module pbus_phase #(
  parameter int WORD_PERIOD = 64,
  localparam int CNT_W = (WORD_PERIOD > 1) ? $clog2(WORD_PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_stb,
  output logic [CNT_W-1:0] phase
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_PERIOD - 1);

  logic [CNT_W-1:0] phase_q;

  // Cycle position inside the word period, re-aligned by every update
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (upd_stb || phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase = phase_q;

  AST_PHASE_REALIGN: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> (phase_q == '0)) else $error("phase not realigned"); // R6

endmodule

// File: rtl/pbus_capture.sv
module pbus_capture
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] word_i,
  output rd_evt_t           evt,
  output logic              oe,
  output logic [DATA_W-1:0] dout
);

  logic              qual;
  logic              oe_q;
  logic [DATA_W-1:0] dout_q;

  assign qual      = ~cs_n & ~rd_n;
  assign evt.start = qual & ~oe_q;
  assign evt.stop  = ~qual & oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      oe_q <= qual;
      if (evt.start) begin
        dout_q <= word_i;
      end
    end
  end

  assign oe   = oe_q;
  assign dout = dout_q;

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (oe_q && $past(oe_q)) |-> $stable(dout_q)) else $error("bus word moved during read"); // R3

endmodule

// File: rtl/pbus_ready.sv
module pbus_ready
  import pbus_pkg::*;
#(
  parameter int WORD_PERIOD = 64,
  parameter int PRE_PULSE   = 2,
  localparam int CNT_W = (WORD_PERIOD > 1) ? $clog2(WORD_PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_stb,
  input  rd_evt_t          evt,
  input  logic [CNT_W-1:0] phase,
  output logic             rdy_n
);

  logic pend_q;
  logic newer_q;
  logic rdy_q;
  logic at_warn;

  generate
    if (PRE_PULSE > 0 && PRE_PULSE < WORD_PERIOD) begin : g_warn
      localparam logic [CNT_W-1:0] WARN = CNT_W'(WORD_PERIOD - PRE_PULSE - 1);
      assign at_warn = (phase == WARN);
    end else begin : g_nowarn
      assign at_warn = 1'b0;
    end
  endgenerate

  // newer_q: an update arrived since the current read began
  always_ff @(posedge clk) begin
    if (rst) begin
      newer_q <= 1'b0;
    end else if (upd_stb) begin
      newer_q <= 1'b1;
    end else if (evt.start) begin
      newer_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (upd_stb) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b1;
    end else if (evt.stop && !newer_q) begin
      rdy_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (pend_q && at_warn) begin
      rdy_q  <= 1'b1;
    end
  end

  assign rdy_n = rdy_q;

  AST_FALL_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !rdy_q) else $error("flag not low after update"); // R4
  AST_READ_DONE: assert property (@(posedge clk) disable iff (rst)
    (evt.stop && !newer_q && !upd_stb) |=> (rdy_q && !pend_q)) else $error("read end not seen"); // R5
  AST_WARN_PULSE: assert property (@(posedge clk) disable iff (rst)
    (pend_q && at_warn && !upd_stb) |=> rdy_q) else $error("missing warning pulse"); // R6
  AST_NEWER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (evt.stop && newer_q && !upd_stb && !at_warn) |=> (pend_q && $stable(rdy_q))) else $error("newer word dropped"); // R7
  AST_UPDATE_WINS: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> pend_q) else $error("update lost"); // R8

endmodule

// File: rtl/pbus_read_if.sv
module pbus_read_if
  import pbus_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int WORD_PERIOD = 64,
  parameter int PRE_PULSE   = 2,
  localparam int CNT_W = (WORD_PERIOD > 1) ? $clog2(WORD_PERIOD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_stb,
  input  logic [DATA_W-1:0] upd_word,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic              rdy_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dq
);

  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  phase;
  rd_evt_t           evt;

  // Output data register, loaded by the core
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (upd_stb) begin
      word_q <= upd_word;
    end
  end

  pbus_phase #(
    .WORD_PERIOD (WORD_PERIOD)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .upd_stb (upd_stb),
    .phase   (phase)
  );

  pbus_capture #(
    .DATA_W (DATA_W)
  ) u_capture (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .word_i (word_q),
    .evt    (evt),
    .oe     (bus_oe),
    .dout   (bus_dq)
  );

  pbus_ready #(
    .WORD_PERIOD (WORD_PERIOD),
    .PRE_PULSE   (PRE_PULSE)
  ) u_ready (
    .clk     (clk),
    .rst     (rst),
    .upd_stb (upd_stb),
    .evt     (evt),
    .phase   (phase),
    .rdy_n   (rdy_n)
  );

  AST_DRIVE_ON_BOTH: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |=> bus_oe) else $error("bus not driven"); // R2
  AST_FLOAT_ON_EITHER: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> !bus_oe) else $error("bus driven without select"); // R2
  AST_WORD_LOADED: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> (word_q == $past(upd_word))) else $error("word not loaded"); // R4

endmodule

// File: tb/pbus_read_if_bench.sv
module pbus_read_if_bench;

  localparam int DW  = 16;
  localparam int P   = 8;
  localparam int PP  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd_stb = 1'b0;
  logic [DW-1:0] upd_word = '0;
  logic          cs_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          rdy_n;
  logic          bus_oe;
  logic [DW-1:0] bus_dq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pbus_read_if #(
    .DATA_W      (DW),
    .WORD_PERIOD (P),
    .PRE_PULSE   (PP)
  ) u_pbus_read_if (
    .clk      (clk),
    .rst      (rst),
    .upd_stb  (upd_stb),
    .upd_word (upd_word),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .rdy_n    (rdy_n),
    .bus_oe   (bus_oe),
    .bus_dq   (bus_dq)
  );

  // Reference state, built from the requirement text
  logic [DW-1:0] m_word = '0;
  logic [DW-1:0] m_dout = '0;
  logic          m_oe = 1'b0;
  logic          m_rdy = 1'b1;
  logic          m_pend = 1'b0;
  logic          m_newer = 1'b0;
  int            m_phase = 0;
  int            n_upd = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("%0t FAIL %s: actual %h expected %h", $time, tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic qual, start, stop, warn;
    qual  = !cs_n && !rd_n;
    start = qual && !m_oe;
    stop  = !qual && m_oe;
    warn  = (m_phase == P - PP - 1);
    if (start) m_dout = m_word;                       // R3
    if (upd_stb) begin                                // R4, R8
      m_rdy = 1'b0; m_pend = 1'b1;
    end else if (stop && !m_newer) begin              // R5, R7
      m_rdy = 1'b1; m_pend = 1'b0;
    end else if (m_pend && warn) begin                // R6
      m_rdy = 1'b1;
    end
    if (upd_stb) m_newer = 1'b1;
    else if (start) m_newer = 1'b0;
    if (upd_stb) m_word = upd_word;
    m_phase = (upd_stb || m_phase == P - 1) ? 0 : m_phase + 1;
    m_oe = qual;                                      // R2
  endtask

  task automatic cycle(input logic s, input logic [DW-1:0] w, input logic c, input logic r);
    upd_stb = s; upd_word = w; cs_n = c; rd_n = r;
    @(negedge clk);
    model_step();
    check("R4/R5/R6/R7/R8/R9 rdy_n", {{(DW-1){1'b0}}, rdy_n}, {{(DW-1){1'b0}}, m_rdy});
    check("R2 bus_oe", {{(DW-1){1'b0}}, bus_oe}, {{(DW-1){1'b0}}, m_oe});
    check("R3 bus_dq", bus_dq, m_dout);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("%0t FAIL watchdog: actual expired expected finished", $time);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdy_n reset", {{(DW-1){1'b0}}, rdy_n}, {{(DW-1){1'b0}}, 1'b1});
    check("R1 bus_oe reset", {{(DW-1){1'b0}}, bus_oe}, '0);
    check("R1 bus_dq reset", bus_dq, '0);
    rst = 1'b0;
    // Sweep read start phase, length and select style
    for (int v = 0; v < 3; v++) begin
      for (int s = 0; s < P; s++) begin
        for (int len = 1; len <= 10; len++) begin
          for (int t = 0; t < 3 * P; t++) begin
            logic stb, win, c, r;
            logic [DW-1:0] w;
            stb = (t % P == 0);
            w = '0;
            if (stb) begin
              n_upd++;
              w = DW'(n_upd * 16'h2F1D) ^ 16'hA5C3;
            end
            win = (t >= P + s) && (t < P + s + len);
            case (v)
              0: begin c = !win; r = !win; end
              1: begin c = 1'b1; r = !win; end      // chip-select off: R2
              default: begin
                c = !win;
                r = !((t >= P + s - 1) && (t <= P + s + len));
              end
            endcase
            cycle(stb, w, c, r);
          end
        end
      end
    end
    // Re-read of an already read word keeps the flag high: R9
    cycle(1'b1, 16'h1234, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) cycle(1'b0, '0, 1'b0, 1'b0);
    for (int k = 0; k < 2; k++) cycle(1'b0, '0, 1'b1, 1'b1);
    for (int k = 0; k < 2; k++) cycle(1'b0, '0, 1'b0, 1'b0);
    cycle(1'b0, '0, 1'b1, 1'b1);
    check("R9 rdy_n after second read", {{(DW-1){1'b0}}, rdy_n}, {{(DW-1){1'b0}}, 1'b1});
    finish_run();
  end

endmodule